// File: doc/BRIEF.md
# Ethernet controller CSR block

This block is the host-facing register file of a small Ethernet controller. A CPU reaches sixteen 32-bit control/status words through a single access port. Each word sits on an eight-byte boundary, so the word index is the byte offset shifted right by three. Offsets that are off that boundary, or that point past the last word, are refused and flagged.

Most words are plain storage. Three of them behave differently:
- The status word is not kept as a flop image. It is assembled at read time from the operating-mode bits and two event flags.
- The missed-frame word reads as zero and is emptied by that read.
- Writing either descriptor-pointer word also loads the matching pointer output used by the DMA engines.

The block exports the receive-enable, transmit-enable and promiscuous controls. It takes single-cycle transmit-done and receive-done pulses that raise the status flags.

Read data is registered. It appears on `rd_data` the cycle after the access and holds until the next read.

Top module: `eth_csr_file`

## Requirements
- R1: While and after reset, `rd_data`, `acc_err`, the three control outputs and both pointer outputs are zero, and every word reads back as zero.
- R2: Word index = `acc_offset` / 8. An access with `acc_offset[2:0]` nonzero, or with index 16 or more, raises `acc_err` for exactly the cycle after the access. Such a write changes no word, and such a read returns zero on `rd_data`.
- R3: Word 6 (offset 0x30) is the mode word. Its bit 1 drives `rx_enable`, bit 6 drives `promisc_enable` and bit 13 drives `tx_enable`, from the cycle after the write.
- R4: A read of word 5 (offset 0x28) returns 3 in bits 19:17 when the receive-enable bit is set, and 3 in bits 22:20 when the transmit-enable bit is set; otherwise those fields are zero.
- R5: The same status read returns the transmit-done flag in bit 0 and the receive-done flag in bit 6. Every other status bit reads zero, whatever was written.
- R6: A `tx_done` or `rx_done` pulse sets flag bit 0 or bit 6. A write to word 5 with a 1 in bit 0 or bit 6 clears that flag, and a 0 leaves it. When a pulse and a clearing write meet in the same cycle, the flag ends set.
- R7: A read of word 8 (offset 0x40) returns zero and empties the stored count.
- R8: A write to word 3 (offset 0x18) loads `rx_desc_ptr`, and a write to word 4 (offset 0x20) loads `tx_desc_ptr`, from the next cycle. Both words also read back the written value.
- R9: Every other word (0-2, 7, 9-15) reads back the last value written to it. A read result is held on `rd_data` until the next read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle invalid-access flag |
| tx_done | input | 1 | Transmit-complete event pulse |
| rx_done | input | 1 | Receive-complete event pulse |
| rx_enable | output | 1 | Receive-enable control |
| tx_enable | output | 1 | Transmit-enable control |
| promisc_enable | output | 1 | Promiscuous-receive control |
| rx_desc_ptr | output | 32 | Current receive descriptor pointer |
| tx_desc_ptr | output | 32 | Current transmit descriptor pointer |

## Verification
Two things can meet in one clock:
- a done pulse and a host write that clears the same status flag;
- a done pulse and a status read.

The bench provokes both by driving `tx_done`/`rx_done` high in the very cycle of a word-5 write or read. It then expects two results:
- the flag ends set after the clash;
- the colliding read shows the flag's value from before the pulse.

The behavioural model applies read-before-update and set-over-clear. Every output is compared against it on every clock.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
   // word indices whose behaviour differs from plain storage
   localparam int RXPTR_IDX  = 3;
   localparam int TXPTR_IDX  = 4;
   localparam int STATUS_IDX = 5;
   localparam int MODE_IDX   = 6;
   localparam int MISS_IDX   = 8;

   // mode word bit positions
   localparam int MODE_RX_BIT = 1;
   localparam int MODE_PR_BIT = 6;
   localparam int MODE_TX_BIT = 13;

   // status word layout
   localparam int STAT_TX_FLAG = 0;
   localparam int STAT_RX_FLAG = 6;
   localparam int STAT_RS_LSB  = 17;
   localparam int STAT_TS_LSB  = 20;
   localparam logic [2:0] STAT_RUN = 3'd3;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/eth_csr_decode.sv
module eth_csr_decode #(
   parameter int OFF_W    = 8,
   parameter int NUM_REGS = 16,
   parameter int STRIDE   = 8,
   localparam int STRIDE_LG = $clog2(STRIDE),
   localparam int IDX_W     = $clog2(NUM_REGS),
   localparam int FULL_W    = OFF_W - STRIDE_LG
) (
   input  logic [OFF_W-1:0] offset,
   output logic [IDX_W-1:0] idx,
   output logic             hit
);
   initial begin
      assert ((1 << STRIDE_LG) == STRIDE) else $fatal(1, "STRIDE must be a power of two");
      assert (FULL_W >= IDX_W) else $fatal(1, "OFF_W too narrow for NUM_REGS");
   end

   logic [FULL_W-1:0] idx_full;
   logic              aligned;

   assign idx_full = offset[OFF_W-1:STRIDE_LG];

   generate
      if (STRIDE_LG > 0) begin : g_align
         assign aligned = (offset[STRIDE_LG-1:0] == '0);
      end else begin : g_noalign
         assign aligned = 1'b1;
      end
   endgenerate

   assign hit = aligned && (32'(idx_full) < 32'(NUM_REGS));
   assign idx = idx_full[IDX_W-1:0];
endmodule

// File: rtl/eth_csr_word.sv
module eth_csr_word #(
   parameter int DATA_W      = 32,
   parameter bit CLR_ON_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   generate
      if (CLR_ON_READ) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (wr_en) q <= wdata;
            else if (rd_en) q <= '0;
         end
         // R7: a read empties the stored count
         p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en) |=> (q == '0));
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (wr_en) q <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/eth_csr_status.sv
module eth_csr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_tx,
   input  logic set_rx,
   input  logic clr_tx,
   input  logic clr_rx,
   output logic tx_flag,
   output logic rx_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_flag <= 1'b0;
         rx_flag <= 1'b0;
      end else begin
         // an event arriving with a clear is kept (set wins)
         if (set_tx)      tx_flag <= 1'b1;
         else if (clr_tx) tx_flag <= 1'b0;
         if (set_rx)      rx_flag <= 1'b1;
         else if (clr_rx) rx_flag <= 1'b0;
      end
   end

   p_set_wins_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_tx |=> tx_flag);
   p_set_wins_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_rx |=> rx_flag);
   p_clear_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tx && !set_tx) |=> !tx_flag);
   p_clear_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rx && !set_rx) |=> !rx_flag);
endmodule

// File: rtl/eth_csr_file.sv
module eth_csr_file
   import eth_csr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 8,
   parameter int NUM_REGS = 16,
   parameter int STRIDE   = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [OFF_W-1:0]  acc_offset,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_err,
   input  logic              tx_done,
   input  logic              rx_done,
   output logic              rx_enable,
   output logic              tx_enable,
   output logic              promisc_enable,
   output logic [DATA_W-1:0] rx_desc_ptr,
   output logic [DATA_W-1:0] tx_desc_ptr
);
   initial begin
      assert (DATA_W >= STAT_TS_LSB + 3) else $fatal(1, "DATA_W too narrow for status layout");
      assert (NUM_REGS > MISS_IDX) else $fatal(1, "NUM_REGS too small");
   end

   logic [IDX_W-1:0] idx;
   logic             hit;
   acc_kind_e        kind;
   logic             wr_ok, rd_ok;

   eth_csr_decode #(.OFF_W(OFF_W), .NUM_REGS(NUM_REGS), .STRIDE(STRIDE)) u_dec (
      .offset(acc_offset), .idx(idx), .hit(hit));

   always_comb begin
      if (!acc_valid)     kind = ACC_NONE;
      else if (acc_write) kind = ACC_WRITE;
      else                kind = ACC_READ;
   end

   assign wr_ok = (kind == ACC_WRITE) && hit;
   assign rd_ok = (kind == ACC_READ) && hit;

   // word storage; the status index holds no image
   logic [NUM_REGS-1:0][DATA_W-1:0] words;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
         if (i == STATUS_IDX) begin : g_stat
            assign words[i] = '0;
         end else begin : g_store
            eth_csr_word #(.DATA_W(DATA_W), .CLR_ON_READ(i == MISS_IDX)) u_word (
               .clk   (clk),
               .rst_n (rst_n),
               .wr_en (wr_ok && (32'(idx) == i)),
               .rd_en (rd_ok && (32'(idx) == i)),
               .wdata (acc_wdata),
               .q     (words[i]));
         end
      end
   endgenerate

   // status flags
   logic tx_flag, rx_flag;
   logic stat_wr;
   assign stat_wr = wr_ok && (32'(idx) == STATUS_IDX);

   eth_csr_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_tx  (tx_done),
      .set_rx  (rx_done),
      .clr_tx  (stat_wr && acc_wdata[STAT_TX_FLAG]),
      .clr_rx  (stat_wr && acc_wdata[STAT_RX_FLAG]),
      .tx_flag (tx_flag),
      .rx_flag (rx_flag));

   // mode controls
   assign rx_enable      = words[MODE_IDX][MODE_RX_BIT];
   assign tx_enable      = words[MODE_IDX][MODE_TX_BIT];
   assign promisc_enable = words[MODE_IDX][MODE_PR_BIT];

   // status built at read time
   logic [DATA_W-1:0] stat_view;
   always_comb begin
      stat_view = '0;
      if (rx_enable) stat_view[STAT_RS_LSB +: 3] = STAT_RUN;
      if (tx_enable) stat_view[STAT_TS_LSB +: 3] = STAT_RUN;
      stat_view[STAT_TX_FLAG] = tx_flag;
      stat_view[STAT_RX_FLAG] = rx_flag;
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      if (!hit)                           rd_mux = '0;
      else if (32'(idx) == STATUS_IDX)    rd_mux = stat_view;
      else if (32'(idx) == MISS_IDX)      rd_mux = '0;
      else                                rd_mux = words[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         acc_err <= 1'b0;
      end else begin
         acc_err <= (kind != ACC_NONE) && !hit;
         if (kind == ACC_READ) rd_data <= rd_mux;
      end
   end

   // descriptor pointers, loaded alongside their words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_desc_ptr <= '0;
         tx_desc_ptr <= '0;
      end else if (wr_ok) begin
         if (32'(idx) == RXPTR_IDX) rx_desc_ptr <= acc_wdata;
         if (32'(idx) == TXPTR_IDX) tx_desc_ptr <= acc_wdata;
      end
   end

   p_err_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(acc_valid));
   p_bad_write_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !hit) |=>
         ($stable(rx_desc_ptr) && $stable(tx_desc_ptr) && $stable(words)));
   p_rxptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && 32'(idx) == RXPTR_IDX) |=> (rx_desc_ptr == $past(acc_wdata)));
   p_txptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && 32'(idx) == TXPTR_IDX) |=> (tx_desc_ptr == $past(acc_wdata)));
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_write) |=> $stable(rd_data));
endmodule

// File: tb/eth_csr_file_test.sv
module eth_csr_file_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [7:0]  acc_offset = '0;
   logic [31:0] acc_wdata = '0;
   logic        tx_done = 1'b0, rx_done = 1'b0;
   logic [31:0] rd_data, rx_desc_ptr, tx_desc_ptr;
   logic        acc_err, rx_enable, tx_enable, promisc_enable;

   always #5 clk = ~clk;

   eth_csr_file uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .acc_err(acc_err), .tx_done(tx_done), .rx_done(rx_done),
      .rx_enable(rx_enable), .tx_enable(tx_enable), .promisc_enable(promisc_enable),
      .rx_desc_ptr(rx_desc_ptr), .tx_desc_ptr(tx_desc_ptr));

   // behavioural reference
   int unsigned m_word [16];
   bit          m_ti, m_ri, m_err;
   int unsigned m_rd, m_rxp, m_txp;
   string       m_tag = "R1";
   int vectors = 0, miscompares = 0;
   bit checking = 0, done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_word[k]) m_word[k] = 0;
         m_ti = 0; m_ri = 0; m_err = 0; m_rd = 0; m_rxp = 0; m_txp = 0; m_tag = "R1";
         checking = 1;
      end else begin
         int unsigned ix;
         bit bad;
         ix  = acc_offset >> 3;
         bad = (acc_offset[2:0] != 0) || (ix >= 16);
         m_err = acc_valid && bad;
         if (acc_valid && !acc_write) begin
            if (bad) begin m_rd = 0; m_tag = "R2"; end
            else if (ix == 5) begin
               m_rd = 0;
               if (m_word[6][1])  m_rd |= 32'h3 << 17;
               if (m_word[6][13]) m_rd |= 32'h3 << 20;
               m_rd |= {25'd0, m_ri, 5'd0, m_ti};
               m_tag = "R4/R5";
            end else if (ix == 8) begin m_rd = 0; m_word[8] = 0; m_tag = "R7"; end
            else begin
               m_rd = m_word[ix];
               m_tag = (ix == 3 || ix == 4) ? "R8" : "R9";
            end
         end
         if (acc_valid && acc_write && !bad) begin
            if (ix == 5) begin
               if (acc_wdata[0]) m_ti = 0;
               if (acc_wdata[6]) m_ri = 0;
            end else begin
               m_word[ix] = acc_wdata;
               if (ix == 3) m_rxp = acc_wdata;
               if (ix == 4) m_txp = acc_wdata;
            end
         end
         if (tx_done) m_ti = 1;
         if (rx_done) m_ri = 1;
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (checking && !done) begin
         string t;
         t = rst_n ? m_tag : "R1";
         cmp({t, " rd_data"}, rd_data, m_rd);
         cmp(rst_n ? "R2 acc_err" : "R1 acc_err", {31'd0, acc_err}, {31'd0, m_err});
         cmp(rst_n ? "R3 rx_enable" : "R1 rx_enable", {31'd0, rx_enable}, {31'd0, m_word[6][1]});
         cmp(rst_n ? "R3 tx_enable" : "R1 tx_enable", {31'd0, tx_enable}, {31'd0, m_word[6][13]});
         cmp(rst_n ? "R3 promisc" : "R1 promisc", {31'd0, promisc_enable}, {31'd0, m_word[6][6]});
         cmp(rst_n ? "R8 rx_desc_ptr" : "R1 rx_desc_ptr", rx_desc_ptr, m_rxp);
         cmp(rst_n ? "R8 tx_desc_ptr" : "R1 tx_desc_ptr", tx_desc_ptr, m_txp);
      end
   end

   task automatic drive(input bit v, input bit w, input logic [7:0] off,
                        input logic [31:0] d, input bit td, input bit rd);
      @(negedge clk);
      #1;
      acc_valid = v; acc_write = w; acc_offset = off; acc_wdata = d;
      tx_done = td; rx_done = rd;
   endtask

   task automatic wr(input logic [7:0] off, input logic [31:0] d);
      drive(1, 1, off, d, 0, 0);
   endtask
   task automatic rd(input logic [7:0] off);
      drive(1, 0, off, 32'h0, 0, 0);
   endtask
   task automatic idle(input int n);
      for (int k = 0; k < n; k++) drive(0, 0, 8'h0, 32'h0, 0, 0);
   endtask

   task automatic finish_run;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #200000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, then all words read zero
      idle(3);
      rst_n = 1'b1;
      idle(1);
      for (int i = 0; i < 16; i++) rd(8'(i * 8));
      // R9 / R8: plain storage and pointer words, two patterns
      for (int i = 0; i < 16; i++) if (i != 5 && i != 6) wr(8'(i * 8), 32'hA5000000 + 32'(i * 32'h01010101));
      for (int i = 0; i < 16; i++) rd(8'(i * 8));
      for (int i = 0; i < 16; i++) if (i != 5 && i != 6) wr(8'(i * 8), ~(32'h13572468 + 32'(i)));
      for (int i = 0; i < 16; i++) rd(8'(i * 8));
      idle(2);
      // R3 / R4: mode combinations with status reads
      wr(8'h30, 32'h0000_0002); rd(8'h28);
      wr(8'h30, 32'h0000_2000); rd(8'h28);
      wr(8'h30, 32'h0000_2042); rd(8'h28);
      wr(8'h30, 32'hFFFF_DFBD); rd(8'h28);
      wr(8'h30, 32'hFFFF_FFFF); rd(8'h28); rd(8'h30);
      // R5 / R6: events, write-1 clears, write-0 keeps
      drive(0, 0, 8'h0, 0, 1, 0); rd(8'h28);
      drive(0, 0, 8'h0, 0, 0, 1); rd(8'h28);
      wr(8'h28, 32'hFFFF_FFBE); rd(8'h28);
      wr(8'h28, 32'h0000_0001); rd(8'h28);
      wr(8'h28, 32'h0000_0040); rd(8'h28);
      // R6 collision: pulse with clearing write, and pulse with status read
      drive(0, 0, 8'h0, 0, 1, 1);
      drive(1, 1, 8'h28, 32'h41, 1, 1); rd(8'h28);
      wr(8'h28, 32'h41); rd(8'h28);
      drive(1, 0, 8'h28, 0, 1, 0); rd(8'h28);
      drive(1, 1, 8'h28, 32'h41, 0, 1); rd(8'h28);
      // R7: missed-frame word read clears
      wr(8'h40, 32'h0000_00FF); rd(8'h40); rd(8'h40); idle(1);
      // R2: invalid offsets
      wr(8'h1C, 32'hDEAD_BEEF); rd(8'h18);
      wr(8'h80, 32'hDEAD_BEEF); rd(8'h00);
      wr(8'hF8, 32'h1234_5678); rd(8'h7C);
      rd(8'h08); rd(8'h81); rd(8'h31); idle(2);
      wr(8'h33, 32'h0); rd(8'h30);
      // R8: pointers back to back
      wr(8'h18, 32'h1000_0000); wr(8'h20, 32'h2000_0000);
      rd(8'h18); rd(8'h20);
      // reset mid-run
      rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
      rd(8'h30); rd(8'h18); idle(3);
      finish_run();
   end
endmodule